// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a synthesizable behavioural model of a single-port synchronous SRAM. It registers the address, the chip select and the write data. Reads are flow-through: the stored word at the current address reaches the output in the same cycle, with no output register. Each word is 36 bits wide and is split into four 9-bit bytes. Every byte holds eight data bits and one parity bit.

A controller starts an access with an address strobe. The block then steps through a four-word group by itself when the advance input is held low. Writes are decided at the end of a cycle and use the address held in the registers. The write control has three levels. A global write input stores the whole word. Otherwise, a byte-write enable lets individual byte selects through. If neither is active, nothing is written.

The bidirectional bus is split into separate ports: `data_i`, `data_o` and an output-drive qualifier `data_oe_o`. A sleep input freezes all internal state and keeps the stored contents.

Top module: `burst_sram`

## Requirements
- R1: A strobe is an edge with `ld_ni` low, or with `ld_gated_ni` low while `en_ni` is low. At a strobe, the address is loaded only when the chip is selected. The chip is selected when `en_ni` is 0, `sel_i` is 1 and `sel_ni` is 0. `ld_gated_ni` has no effect while `en_ni` is high.
- R2: A rising edge with `wr_all_ni` low, while the chip is selected, writes all four bytes of `data_i`. This holds whatever the byte-write inputs are.
- R3: With `wr_all_ni` high and `byte_wr_en_ni` low, every byte whose `byte_sel_ni[b]` is 0 is written. Every byte whose `byte_sel_ni[b]` is 1 keeps its old value.
- R4: With `wr_all_ni` and `byte_wr_en_ni` both high, `byte_sel_ni` is ignored and no byte is written.
- R5: Byte b consists of bits `8b+7..8b` of the word plus parity bit `32+b`. `byte_sel_ni[b]` controls exactly that byte.
- R6: `data_o` shows the stored word at the current burst address in the same cycle. A write becomes visible in the cycle after its edge.
- R7: `data_oe_o` is 1 only when all of these hold: the chip is selected, `out_en_ni` is 0, no byte write is active on the current inputs, and the block is not asleep. It follows `out_en_ni` without waiting for a clock.
- R8: A strobe while the chip is not selected drops `data_oe_o` from the next cycle on. A strobe while the chip is selected restores reads from the next cycle on.
- R9: With the chip selected, `burst_adv_ni` low and no strobe, the 2-bit burst count steps modulo 4 at each edge. The two low address bits are then `base+count` (mod 4) when `burst_ilv_i` is 0, or `base XOR count` when it is 1. The upper address bits never change during a burst.
- R10: While `sleep_i` is 1, no register and no stored word changes, and `data_oe_o` is 0. The contents are kept.
- R11: After reset the block is deselected, so `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze internal state, keep contents |
| en_ni | input | 1 | Chip enable, active low; also gates `ld_gated_ni` |
| sel_i | input | 1 | Chip select, active high |
| sel_ni | input | 1 | Chip select, active low |
| ld_gated_ni | input | 1 | Address strobe, gated by `en_ni` |
| ld_ni | input | 1 | Address strobe, ungated |
| burst_adv_ni | input | 1 | Advance the burst count |
| burst_ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | Word address |
| wr_all_ni | input | 1 | Write the whole word |
| byte_wr_en_ni | input | 1 | Pass the per-byte selects through |
| byte_sel_ni | input | 4 | Per-byte write selects, active low |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| data_i | input | 36 | Write data |
| data_o | output | 36 | Read data, flow-through |
| data_oe_o | output | 1 | Qualifies `data_o` as driven |

## Verification
A wrong burst count or base register shows as a wrong word on `data_o` in the very next cycle, because reads are not registered. A bad byte mask shows one cycle after the write edge: the affected 9-bit lane, or its parity bit, differs from the reference. A select flag that is stuck or late shows on `data_oe_o` in the cycle after a strobe. A leaking sleep gate shows as a moved address or an altered word once sleep is released.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BYTES     = 4;
  localparam int BYTE_DW   = 8;
  localparam int LANE_W    = BYTE_DW + 1;
  localparam int WORD_W    = BYTES * LANE_W;
  localparam int PAR_LSB   = BYTES * BYTE_DW;
  localparam int BURST_W   = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t get_lane(word_t w, int b);
    return {w[PAR_LSB+b], w[b*BYTE_DW +: BYTE_DW]};
  endfunction

  function automatic logic [BURST_W-1:0] burst_low(
      logic [BURST_W-1:0] base, logic [BURST_W-1:0] cnt, logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              en_ni,
  input  logic              sel_i,
  input  logic              sel_ni,
  input  logic              ld_gated_ni,
  input  logic              ld_ni,
  input  logic              burst_adv_ni,
  input  logic              burst_ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               sel_q;
  logic               strobe, chip_on;

  assign strobe  = ~ld_ni | (~ld_gated_ni & ~en_ni);
  assign chip_on = ~en_ni & sel_i & ~sel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (run_i) begin
      if (strobe) begin
        sel_q <= chip_on;
        if (chip_on) begin
          base_q <= addr_i;
          cnt_q  <= '0;
        end
      end else if (sel_q && !burst_adv_ni) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign addr_o = {base_q[ADDR_W-1:BURST_W],
                   burst_low(base_q[BURST_W-1:0], cnt_q, burst_ilv_i)};
  assign sel_o  = sel_q;

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !strobe) |=> (base_q[ADDR_W-1:BURST_W] == $past(base_q[ADDR_W-1:BURST_W]))); // R9
endmodule

// File: rtl/burst_sram_wgate.sv
module burst_sram_wgate
  import burst_sram_pkg::*;
(
  input  logic             wr_all_ni,
  input  logic             byte_wr_en_ni,
  input  logic [BYTES-1:0] byte_sel_ni,
  output logic [BYTES-1:0] lane_we_o,
  output logic             wr_any_o
);
  always_comb begin
    if (!wr_all_ni)          lane_we_o = '1;
    else if (!byte_wr_en_ni) lane_we_o = ~byte_sel_ni;
    else                     lane_we_o = '0;
  end
  assign wr_any_o = |lane_we_o;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [BYTES-1:0]  lane_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o
);
  word_t mem [DEPTH];
  word_t bit_mask, merged;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign bit_mask[b*BYTE_DW +: BYTE_DW] = {BYTE_DW{lane_we_i[b]}};
    assign bit_mask[PAR_LSB+b]            = lane_we_i[b];
  end

  assign rdata_o = mem[addr_i];
  assign merged  = (rdata_o & ~bit_mask) | (wdata_i & bit_mask);

  always_ff @(posedge clk_i) begin
    if (|lane_we_i) mem[addr_i] <= merged;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              en_ni,
  input  logic              sel_i,
  input  logic              sel_ni,
  input  logic              ld_gated_ni,
  input  logic              ld_ni,
  input  logic              burst_adv_ni,
  input  logic              burst_ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_all_ni,
  input  logic              byte_wr_en_ni,
  input  logic [BYTES-1:0]  byte_sel_ni,
  input  logic              out_en_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              run;
  logic [ADDR_W-1:0] cur_addr;
  logic              sel_q, wr_any;
  logic [BYTES-1:0]  lane_we, lane_we_g;

  assign run = ~sleep_i;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .run_i(run), .en_ni, .sel_i, .sel_ni,
    .ld_gated_ni, .ld_ni, .burst_adv_ni, .burst_ilv_i, .addr_i,
    .addr_o(cur_addr), .sel_o(sel_q)
  );

  burst_sram_wgate u_wgate (
    .wr_all_ni, .byte_wr_en_ni, .byte_sel_ni,
    .lane_we_o(lane_we), .wr_any_o(wr_any)
  );

  assign lane_we_g = lane_we & {BYTES{sel_q & run}};

  burst_sram_array #(.DEPTH(DEPTH)) u_array (
    .clk_i, .lane_we_i(lane_we_g), .addr_i(cur_addr),
    .wdata_i(data_i), .rdata_o(data_o)
  );

  assign data_oe_o = sel_q & ~out_en_ni & ~wr_any & run;

  // observation terms for the checks below
  logic strobe_in, chip_on_in, hold;
  assign strobe_in  = ~ld_ni | (~ld_gated_ni & ~en_ni);
  assign chip_on_in = ~en_ni & sel_i & ~sel_ni;
  assign hold       = run & ~strobe_in & burst_adv_ni;

  AST_DESEL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && strobe_in && !chip_on_in) |=> !data_oe_o); // R8
  AST_WR_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && sel_q && !wr_all_ni) |=> (data_o == $past(data_i))); // R2
  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && wr_all_ni && byte_wr_en_ni) |=> $stable(data_o)); // R4
  AST_SLEEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(cur_addr) && $stable(sel_q) && $stable(data_o))); // R10
  for (genvar b = 0; b < BYTES; b++) begin : g_keep
    AST_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold && wr_all_ni && !byte_wr_en_ni && byte_sel_ni[b])
      |=> (get_lane(data_o, b) == $past(get_lane(data_o, b)))); // R3
  end
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic sleep = 0, en_n = 1, sel = 1, sel_n = 0, ldg_n = 1, ld_n = 1;
  logic adv_n = 1, ilv = 0, wall_n = 1, bwen_n = 1, oe_n = 0;
  logic [3:0]  bsel_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        doe;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [35:0] mdl [DEPTH];
  bit          known [DEPTH];
  bit          m_sel = 0;
  int          m_base = 0, m_cnt = 0;

  always #4 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH)) u_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .en_ni(en_n), .sel_i(sel),
    .sel_ni(sel_n), .ld_gated_ni(ldg_n), .ld_ni(ld_n), .burst_adv_ni(adv_n),
    .burst_ilv_i(ilv), .addr_i(addr), .wr_all_ni(wall_n),
    .byte_wr_en_ni(bwen_n), .byte_sel_ni(bsel_n), .out_en_ni(oe_n),
    .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  function automatic int m_addr();
    int lo;
    lo = ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  function automatic logic [3:0] m_mask();
    if (!wall_n) return 4'hF;
    if (!bwen_n) return ~bsel_n;
    return 4'h0;
  endfunction

  function automatic logic [35:0] pat(int a, int salt);
    logic [31:0] v;
    v = 32'(a) * 32'h0101_0101 ^ 32'hA5C3_0F96 ^ 32'(salt * 32'h1357_9BDF);
    return {4'(a + salt), v};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // check outputs mid-cycle, then apply the edge to the reference
  task automatic step(string tag);
    logic [3:0]  mk;
    logic [35:0] w;
    bit          strobe, on;
    int          a;
    #1;
    mk = m_mask();
    chk({tag, " R7 oe"}, 36'(doe), 36'(m_sel && !oe_n && mk == 0 && !sleep));
    a = m_addr();
    if (m_sel && known[a]) chk({tag, " R6 data"}, dout, mdl[a]);
    @(posedge clk);
    if (!sleep) begin
      if (m_sel && mk != 0) begin
        w = mdl[a];
        for (int b = 0; b < 4; b++)
          if (mk[b]) begin
            w[b*8 +: 8] = din[b*8 +: 8];
            w[32+b]     = din[32+b];
          end
        mdl[a] = w;
      end
      strobe = !ld_n || (!ldg_n && !en_n);
      on     = !en_n && sel && !sel_n;
      if (strobe) begin
        m_sel = on;
        if (on) begin m_base = int'(addr); m_cnt = 0; end
      end else if (m_sel && !adv_n) m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ld_n = 1; ldg_n = 1; adv_n = 1; wall_n = 1; bwen_n = 1; bsel_n = 4'hF;
  endtask

  task automatic load(int a, string tag);
    idle(); en_n = 0; sel = 1; sel_n = 0; ld_n = 0; addr = AW'(a);
    step(tag);
    idle();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [35:0] old;
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 oe in reset", 36'(doe), 36'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 oe after reset", 36'(doe), 36'h0);

    // fill with global writes over linear bursts
    for (int g = 0; g < DEPTH / 4; g++) begin
      load(g * 4, "R1 fill load");
      for (int j = 0; j < 4; j++) begin
        wall_n = 0; bwen_n = j[0]; bsel_n = 4'(j * 5);
        din = pat(g * 4 + j, 0); adv_n = 0;
        step("R2 fill");
        known[g * 4 + j] = 1;
      end
      idle();
    end

    // linear then interleaved burst from an odd base
    ilv = 0; load(33, "R1 load");
    for (int j = 0; j < 5; j++) begin adv_n = 0; step("R9 linear"); end
    ilv = 1; load(37, "R1 load");
    for (int j = 0; j < 5; j++) begin adv_n = 0; step("R9 interleaved"); end
    ilv = 0;

    // byte writes: mixed mask and each single lane
    load(9, "R1 load");
    wall_n = 1; bwen_n = 0; bsel_n = 4'b1010; din = 36'hF_FFFF_FFFF;
    step("R3 mixed lanes"); idle(); step("R3 readback");
    for (int b = 0; b < 4; b++) begin
      load(12 + b, "R1 load");
      bwen_n = 0; bsel_n = ~(4'b1 << b); din = pat(b, 7);
      step("R5 single lane"); idle(); step("R5 readback");
    end

    // byte selects blocked when the enable is high
    load(20, "R1 load");
    bwen_n = 1; bsel_n = 4'h0; din = 36'h0;
    step("R4 blocked"); idle(); step("R4 readback");
    chk("R4 word kept", dout, pat(20, 0));

    // global write overrides blocked byte selects
    wall_n = 0; bwen_n = 1; bsel_n = 4'b0110; din = pat(99, 3);
    step("R2 override"); idle(); step("R2 readback");
    chk("R2 all lanes", dout, pat(99, 3));

    // gated strobe ignored while chip enable is high
    load(40, "R1 load");
    en_n = 1; ldg_n = 0; addr = AW'(80);
    step("R1 gated ignored"); idle(); en_n = 0;
    step("R1 readback");
    chk("R1 address kept", dout, pat(40, 0));

    // deselect with a strobe, then reselect
    sel = 0; ld_n = 0; addr = AW'(50);
    step("R8 deselect"); idle(); sel = 1;
    chk("R8 oe low next cycle", 36'(doe), 36'h0);
    step("R8 deselected");
    load(50, "R8 reselect");
    chk("R8 oe back", 36'(doe), 36'h1);
    chk("R8 data back", dout, pat(50, 0));

    // asynchronous output enable
    oe_n = 1; #1 chk("R7 oe_n high", 36'(doe), 36'h0);
    oe_n = 0; #1 chk("R7 oe_n low", 36'(doe), 36'h1);
    @(negedge clk);

    // sleep: write and strobe are ignored
    old = pat(50, 0);
    sleep = 1; wall_n = 0; din = 36'h0; ld_n = 0; addr = AW'(60);
    step("R10 sleep"); step("R10 sleep");
    sleep = 0; idle();
    step("R10 wake");
    chk("R10 contents kept", dout, old);
    chk("R10 oe after wake", 36'(doe), 36'h1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule